// File: doc/BRIEF.md
# I2C Byte Shift Register

This block is the byte-wide data path of an I2C serial interface. A single 8-bit shift register carries both the byte being sent and the byte being received. A 3-bit bit counter tracks how far a byte has progressed. The CPU loads a byte through a write port and can read the register at any time. The bus timing logic delivers single-cycle strobes for each rising and falling SCL edge. On every falling edge the register moves one place toward its top bit, and the SDA level captured at the preceding rising edge enters at the bottom. The top bit drives the serial data output, so a byte goes out most significant bit first. When one byte is complete, the received byte (or the read-back of the transmitted byte) is left in the register.

A CPU write is taken only while the serial enable control is set. An accepted write restarts the bit counter and clears the byte-complete flag. In master mode it also pulses a request that tells the SCL generator to start clocking. When software drops the master-mode status to enter slave mode, writes are blocked for a guard window of several clock cycles.

Top module: `i2c_byte_shifter`

## Requirements
- R1: A write with `wr_en`=1, `serial_en`=1 and no guard window active is accepted. `rd_data` shows the written byte in the cycle after the clock edge.
- R2: `sda_out` always equals bit 7 of the register, so bytes leave MSB first. Each qualifying `scl_fall` strobe shifts the register one place toward bit 7.
- R3: On each `scl_rise` strobe the SDA level on `sda_in` is captured. It enters bit 0 at the next shifting `scl_fall`. After 8 shifts, `rd_data` holds the received byte with the first bit at bit 7.
- R4: While `serial_en`=0, CPU writes are ignored and the register does not shift.
- R5: An accepted write clears the bit counter and `byte_done`. Eight further shifts are then needed before `byte_done` rises again.
- R6: `clk_start_req` pulses high for exactly one cycle, in the cycle after an accepted write made with `master_mode`=1. It stays low for writes in slave mode.
- R7: `byte_done` rises right after the 8th shifting `scl_fall` since the last accepted write. It then holds, and further `scl_fall` strobes leave the register unchanged until the next accepted write. Reset clears it.
- R8: Suppose `master_mode` is sampled 1 at one clock edge and 0 at the next edge E. Then writes presented at edge E and at the following `GUARD_CYCLES` (default 8) edges are ignored. A write at the edge after that window is accepted.
- R9: `rd_data` presents the register contents at all times, whatever the value of `serial_en`.
- R10: If an accepted write and an `scl_fall` strobe arrive in the same cycle, the write wins. The written byte is loaded unshifted, and the counter starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write byte |
| rd_data | output | 8 | Current register contents for CPU reads |
| serial_en | input | 1 | Serial interface enable control bit |
| master_mode | input | 1 | Master-mode status bit (1 = master) |
| scl_rise | input | 1 | Single-cycle strobe on each SCL rising edge |
| scl_fall | input | 1 | Single-cycle strobe on each SCL falling edge |
| sda_in | input | 1 | Sampled SDA bus level |
| sda_out | output | 1 | Serial data bit to drive onto SDA |
| clk_start_req | output | 1 | One-cycle request to start SCL clocking |
| byte_done | output | 1 | Eight bits have shifted since the last accepted write |

## Verification
The bench targets the edges of the slave-mode guard window. A write in the very cycle that `master_mode` falls, and one at the last blocked edge, must both be dropped, and the first write after the window must land. A design off by one there would either corrupt the register or lose a legitimate write. It also drives a write coinciding with an SCL falling strobe: a design that let the shift win would load a displaced byte or leave the counter one step ahead and end the byte early. Other directed cases cover writes with the enable clear, strobes arriving after `byte_done`, and the start request in slave mode. A design that lets any of these through changes `rd_data` or pulses `clk_start_req` where the bench's model does not. Random traffic then compares every output against that model on every cycle.

// File: rtl/i2c_shift_pkg.sv
package i2c_shift_pkg;
   localparam int unsigned BYTE_W_DEF   = 8;
   localparam int unsigned GUARD_DEF    = 8;

   typedef struct packed {
      logic rise;
      logic fall;
   } scl_evt_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/i2c_sr_guard.sv
module i2c_sr_guard #(
   parameter int unsigned GUARD_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic master_mode,
   output logic block
);
   localparam int unsigned GW = $clog2(GUARD_CYCLES + 2);

   generate
      if (GUARD_CYCLES == 0) begin : g_noguard
         assign block = 1'b0;
      end else begin : g_guard
         logic          mm_q;
         logic [GW-1:0] remain;
         logic          mm_drop;

         assign mm_drop = mm_q & ~master_mode;
         assign block   = mm_drop | (remain != '0);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mm_q   <= 1'b0;
               remain <= '0;
            end else begin
               mm_q <= master_mode;
               if (mm_drop)
                  remain <= GW'(GUARD_CYCLES);
               else if (remain != '0)
                  remain <= remain - 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_sr_bitcnt.sv
module i2c_sr_bitcnt #(
   parameter int unsigned DATA_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic done
);
   localparam int unsigned CW   = i2c_shift_pkg::cnt_width(DATA_W);
   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (clear) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (step && !done) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            done <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_sr_datapath.sv
module i2c_sr_datapath #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   input  i2c_shift_pkg::scl_evt_t evt,
   input  logic              sda_in,
   output logic [DATA_W-1:0] q
);
   logic sample_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sample_q <= 1'b0;
      else if (evt.rise)
         sample_q <= sda_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= load_data;
      else if (shift)
         q <= {q[DATA_W-2:0], sample_q};
   end
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
   parameter int unsigned DATA_W       = i2c_shift_pkg::BYTE_W_DEF,
   parameter int unsigned GUARD_CYCLES = i2c_shift_pkg::GUARD_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              serial_en,
   input  logic              master_mode,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_in,
   output logic              sda_out,
   output logic              clk_start_req,
   output logic              byte_done
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("i2c_byte_shifter: DATA_W must be at least 2");
      end
   endgenerate

   i2c_shift_pkg::scl_evt_t evt;
   logic guard_block;
   logic wr_accept;
   logic do_shift;
   logic req_q;

   assign evt.rise  = scl_rise;
   assign evt.fall  = scl_fall;

   i2c_sr_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .master_mode (master_mode),
      .block       (guard_block)
   );

   assign wr_accept = wr_en & serial_en & ~guard_block;
   assign do_shift  = evt.fall & serial_en & ~byte_done & ~wr_accept;

   i2c_sr_bitcnt #(.DATA_W(DATA_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (wr_accept),
      .step  (do_shift),
      .done  (byte_done)
   );

   i2c_sr_datapath #(.DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_accept),
      .load_data (wr_data),
      .shift     (do_shift),
      .evt       (evt),
      .sda_in    (sda_in),
      .q         (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         req_q <= 1'b0;
      else
         req_q <= wr_accept & master_mode;
   end

   assign clk_start_req = req_q;
   assign sda_out       = rd_data[DATA_W-1];
endmodule

// File: rtl/i2c_sr_checker.sv
module i2c_sr_checker #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned GUARD_CYCLES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              serial_en,
   input logic              master_mode,
   input logic              scl_fall,
   input logic [DATA_W-1:0] rd_data,
   input logic              clk_start_req,
   input logic              byte_done,
   input logic              wr_accept
);
   localparam int unsigned GW = $clog2(GUARD_CYCLES + 2);

   logic          mm_seen;
   logic [GW-1:0] win;
   logic          in_window;

   assign in_window = (mm_seen & ~master_mode) | (win != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mm_seen <= 1'b0;
         win     <= '0;
      end else begin
         mm_seen <= master_mode;
         if (mm_seen && !master_mode)
            win <= GW'(GUARD_CYCLES);
         else if (win != '0)
            win <= win - 1'b1;
      end
   end

   assert_disabled_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !serial_en |=> $stable(rd_data));

   assert_start_after_master_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clk_start_req |-> $past(wr_accept && master_mode));

   assert_write_clears_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |=> !byte_done);

   assert_done_from_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(byte_done) |-> $past(scl_fall && serial_en));

   assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !wr_accept) |=> (byte_done && $stable(rd_data)));

   assert_guard_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_window |-> !wr_accept);

   assert_shift_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_fall && serial_en && !byte_done && !wr_accept) |=>
         (rd_data[DATA_W-1:1] == $past(rd_data[DATA_W-2:0])));
endmodule

bind i2c_byte_shifter i2c_sr_checker #(
   .DATA_W       (DATA_W),
   .GUARD_CYCLES (GUARD_CYCLES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .serial_en     (serial_en),
   .master_mode   (master_mode),
   .scl_fall      (scl_fall),
   .rd_data       (rd_data),
   .clk_start_req (clk_start_req),
   .byte_done     (byte_done),
   .wr_accept     (wr_accept)
);

// File: tb/i2c_byte_shifter_tb.sv
module i2c_byte_shifter_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, serial_en, master_mode, scl_rise, scl_fall, sda_in;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       sda_out, clk_start_req, byte_done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference model state
   logic [7:0] m_sh;
   int         m_cnt, m_g;
   logic       m_done, m_req, m_smp, m_mmq, m_valid;

   always #2 clk = ~clk;

   i2c_byte_shifter u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .serial_en(serial_en), .master_mode(master_mode),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
      .sda_out(sda_out), .clk_start_req(clk_start_req), .byte_done(byte_done)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic shifted_bit(input logic [7:0] v, input int k);
      return v[7-k];
   endfunction

   task automatic model_update();
      logic mmfall, acc, sh;
      mmfall = m_mmq && !master_mode;
      acc    = wr_en && serial_en && !mmfall && (m_g == 0);
      if (mmfall) m_g = 8;
      else if (m_g > 0) m_g--;
      m_mmq = master_mode;
      m_req = acc && master_mode;
      sh    = scl_fall && serial_en && !m_done && !acc;
      if (acc) begin
         m_sh = wr_data; m_cnt = 0; m_done = 0; m_valid = 1;
      end else if (sh) begin
         m_sh = {m_sh[6:0], m_smp};
         m_cnt++;
         if (m_cnt == 8) begin m_done = 1; m_cnt = 0; end
      end
      if (scl_rise) m_smp = sda_in;
   endtask

   task automatic compare_model();
      check("R6 clk_start_req", clk_start_req, m_req);
      check("R7 byte_done", byte_done, m_done);
      if (m_valid) begin
         check("R3 rd_data", rd_data, m_sh);
         check("R2 sda_out", sda_out, m_sh[7]);
      end
   endtask

   // inputs set just after a negedge; one clock edge; compare at next negedge
   task automatic step(input logic wr, input logic [7:0] d, input logic se, input logic mm,
                       input logic rise, input logic fall, input logic sda);
      wr_en = wr; wr_data = d; serial_en = se; master_mode = mm;
      scl_rise = rise; scl_fall = fall; sda_in = sda;
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_model();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rx;
      void'($urandom(32'h5EED_1C2A));
      m_sh = 0; m_cnt = 0; m_g = 0; m_done = 0; m_req = 0; m_smp = 0; m_mmq = 0; m_valid = 0;
      rst_n = 0; wr_en = 0; wr_data = 0; serial_en = 0; master_mode = 0;
      scl_rise = 0; scl_fall = 0; sda_in = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      check("R7 reset byte_done", byte_done, 0);
      check("R6 reset clk_start_req", clk_start_req, 0);

      // R1 accepted write, slave mode
      step(1, 8'h3C, 1, 0, 0, 0, 0);
      check("R1 write loads", rd_data, 8'h3C);
      check("R2 msb on sda_out", sda_out, 0);
      check("R6 no request in slave", clk_start_req, 0);

      // R4 / R9 write ignored while disabled, read still works
      step(1, 8'hFF, 0, 0, 0, 0, 0);
      check("R4 disabled write ignored", rd_data, 8'h3C);
      step(0, 8'h00, 0, 0, 0, 1, 1);
      check("R9 read while disabled", rd_data, 8'h3C);

      // R6 master write requests clock
      step(1, 8'h96, 1, 1, 0, 0, 0);
      check("R6 request pulse", clk_start_req, 1);
      check("R5 done cleared", byte_done, 0);
      step(0, 8'h00, 1, 1, 0, 0, 0);
      check("R6 request single cycle", clk_start_req, 0);

      // R2 transmit with loopback, MSB first
      for (int k = 0; k < 8; k++) begin
         check("R2 bit order", sda_out, shifted_bit(8'h96, k));
         step(0, 8'h00, 1, 1, 1, 0, sda_out);
         step(0, 8'h00, 1, 1, 0, 1, 0);
         if (k < 7) check("R5 not done early", byte_done, 0);
      end
      check("R7 done after 8", byte_done, 1);
      check("R3 loopback byte", rd_data, 8'h96);
      step(0, 8'h00, 1, 1, 1, 0, 0);
      step(0, 8'h00, 1, 1, 0, 1, 0);
      check("R7 frozen after done", rd_data, 8'h96);

      // R10 write and fall together
      step(1, 8'h81, 1, 1, 0, 1, 0);
      check("R10 write wins", rd_data, 8'h81);
      check("R10 done clear", byte_done, 0);

      // R8 guard window after master -> slave
      step(1, 8'h11, 1, 0, 0, 0, 0);
      check("R8 write at fall edge ignored", rd_data, 8'h81);
      for (int k = 0; k < 8; k++) begin
         step(1, 8'h22, 1, 0, 0, 0, 0);
         check("R8 write inside window ignored", rd_data, 8'h81);
      end
      step(1, 8'h5A, 1, 0, 0, 0, 0);
      check("R8 write after window", rd_data, 8'h5A);
      check("R6 no request after slave write", clk_start_req, 0);

      // R3 receive 0xC3
      rx = 8'hC3;
      for (int k = 0; k < 8; k++) begin
         step(0, 8'h00, 1, 0, 1, 0, rx[7-k]);
         step(0, 8'h00, 1, 0, 0, 1, 0);
      end
      check("R3 received byte", rd_data, 8'hC3);
      check("R7 done after receive", byte_done, 1);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         logic mm_next;
         int sel;
         mm_next = ($urandom % 48 == 0) ? ~master_mode : master_mode;
         sel = $urandom % 4;
         step(($urandom % 12) == 0, 8'($urandom), ($urandom % 10) != 0, mm_next,
              sel == 0, sel == 1, 1'($urandom));
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule